// File: doc/BRIEF.md
# Query Sequence Writeback Unit

This block is one register-mapped slice of a graphics engine. It takes a stream of method writes, each an index and a 32-bit value, and stores every value in a flat word array at the position the index names. The array has `REG_COUNT` words and is 0xE36 words by default.

Four words at fixed positions form a query group:
- 0x6C0 holds the upper half of a 64-bit target address.
- 0x6C1 holds the lower half of that address.
- 0x6C2 holds a sequence value.
- 0x6C3 is a trigger.

Writing the trigger with the write mode makes the block issue one memory write request. The request carries the 32-bit sequence value to the 64-bit address. The address is used exactly as written, with no translation.

Other trigger modes are not supported. They raise a one-cycle error flag instead of a request. An index beyond the array is dropped and raises its own one-cycle flag. While a memory request waits for acceptance, the method input is held off. A combinational read port lets the surrounding logic inspect any word of the array.

The control path is a two-state machine:
- `ST_IDLE` accepts methods. It moves to `ST_ISSUE` when a write-mode trigger is accepted.
- `ST_ISSUE` holds the request. It returns to `ST_IDLE` in the cycle `wr_ready` is high.

Top module: `qsw_engine`

## Requirements
- R1: After reset, `mth_ready` is 1, and `wr_valid`, `err_mode` and `err_index` are 0.
- R2: A method accepted (`mth_valid` and `mth_ready` high at a clock edge) with an index below `REG_COUNT` stores its value at that index. `rd_data` shows the stored value for `rd_index` from the cycle after acceptance, up to and including index `REG_COUNT-1`.
- R3: A trigger write (index 0x6C3) whose bits 1:0 equal 0 raises `wr_valid` in the cycle after acceptance. The request has `wr_addr = {word 0x6C0, word 0x6C1}` and `wr_data = word 0x6C2`.
- R4: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold their values. One transfer (`wr_valid` and `wr_ready` high) completes a request, and `wr_valid` is low in the next cycle.
- R5: `mth_ready` is low in every cycle `wr_valid` is high. A method presented then waits and is stored once the request has completed.
- R6: A trigger write whose bits 1:0 are 1, 2 or 3 issues no request. It sets `err_mode` high for exactly the one cycle after acceptance.
- R7: A method with index at or above `REG_COUNT` (0xE36) is dropped and sets `err_index` high for exactly the one cycle after acceptance. No word of the array changes.
- R8: The trigger word is stored like any other word, so reading index 0x6C3 returns the last trigger value written, whatever its mode.
- R9: Bit 4 (fence) and bits 15:12 (unit) of the trigger word do not change the request that mode 0 produces.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mth_valid | input | 1 | A method write is presented |
| mth_ready | output | 1 | Method input can accept this cycle |
| mth_index | input | 12 | Word index of the method |
| mth_data | input | 32 | Value of the method |
| rd_index | input | 12 | Index for combinational read-back |
| rd_data | output | 32 | Word at `rd_index` (0 if out of range) |
| wr_valid | output | 1 | Memory write request pending |
| wr_ready | input | 1 | Memory side accepts the request |
| wr_addr | output | 64 | Target address of the request |
| wr_data | output | 32 | Sequence word to be written |
| err_mode | output | 1 | One-cycle flag: unsupported trigger mode |
| err_index | output | 1 | One-cycle flag: method index out of range |

## Verification
The bench stalls the memory side for several cycles and checks that the request neither drifts nor repeats. A design that sampled the query words live, or re-issued on each ready cycle, would deliver a wrong or duplicate write to the scoreboard. It sets the fence and unit bits alongside mode 0, and sends triggers with modes 1 and 3. A decoder that used too many mode bits would then either drop a valid request or emit a forbidden one. It writes index 0xE35, the last legal word, and indices 0xE36 and 0xFFF, the first and far illegal ones. An off-by-one bound would either flag a legal write or corrupt state that a later trigger reads back.

// File: rtl/qsw_pkg.sv
package qsw_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } qsw_state_e;

    // Word positions of the query group inside the register array
    localparam int unsigned QRY_HI_IDX  = 'h6C0;
    localparam int unsigned QRY_LO_IDX  = 'h6C1;
    localparam int unsigned QRY_SEQ_IDX = 'h6C2;
    localparam int unsigned QRY_GET_IDX = 'h6C3;

    // Trigger word layout: mode in the low bits
    localparam int unsigned MODE_W     = 2;
    localparam logic [1:0]  MODE_WRITE = 2'd0;
endpackage

// File: rtl/qsw_regfile.sv
module qsw_regfile
    import qsw_pkg::*;
#(
    parameter int unsigned REG_COUNT = 'hE36,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned IDX_W     = $clog2(REG_COUNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] tap_hi,
    output logic [DATA_W-1:0] tap_lo,
    output logic [DATA_W-1:0] tap_seq,
    output logic              err_idx
);
    logic [DATA_W-1:0] mem [REG_COUNT];
    logic              in_range;

    assign in_range = (int'(widx) < int'(REG_COUNT));

    // Storage array: no reset, written only for legal indices
    always_ff @(posedge clk) begin
        if (we && in_range) begin
            mem[widx] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_idx <= 1'b0;
        end else begin
            err_idx <= we && !in_range;
        end
    end

    always_comb begin
        rdata = '0;
        if (int'(ridx) < int'(REG_COUNT)) begin
            rdata = mem[ridx];
        end
    end

    assign tap_hi  = mem[QRY_HI_IDX];
    assign tap_lo  = mem[QRY_LO_IDX];
    assign tap_seq = mem[QRY_SEQ_IDX];

    // R7
    idx_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (int'(widx) >= int'(REG_COUNT))) |=> err_idx);

    // R7
    idx_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && in_range) |=> !err_idx);
endmodule

// File: rtl/qsw_query_fsm.sv
module qsw_query_fsm
    import qsw_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_acc,
    input  logic [MODE_W-1:0] trig_mode,
    input  logic [DATA_W-1:0] tap_hi,
    input  logic [DATA_W-1:0] tap_lo,
    input  logic [DATA_W-1:0] tap_seq,
    input  logic              wr_ready,
    output logic              in_ready,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              err_mode
);
    qsw_state_e state, state_nx;
    logic       go_write;
    logic       go_bad;

    assign go_write = trig_acc && (trig_mode == MODE_WRITE);
    assign go_bad   = trig_acc && (trig_mode != MODE_WRITE);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (go_write) state_nx = ST_ISSUE;
            ST_ISSUE: if (wr_ready) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Registered outputs: request payload captured at trigger, error pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_addr  <= '0;
            wr_data  <= '0;
            err_mode <= 1'b0;
        end else begin
            err_mode <= go_bad;
            if (go_write) begin
                wr_addr <= {tap_hi, tap_lo};
                wr_data <= tap_seq;
            end
        end
    end

    always_comb begin
        in_ready = (state == ST_IDLE);
        wr_valid = (state == ST_ISSUE);
    end

    // R3
    trig_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go_write |=> (wr_valid && wr_addr == $past({tap_hi, tap_lo}) && wr_data == $past(tap_seq)));

    // R4
    hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    // R4
    single_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> !wr_valid);

    // R6
    mode_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go_bad |=> (err_mode && !wr_valid));

    // R5
    input_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !in_ready);
endmodule

// File: rtl/qsw_engine.sv
module qsw_engine
    import qsw_pkg::*;
#(
    parameter int unsigned REG_COUNT = 'hE36,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned IDX_W     = $clog2(REG_COUNT),
    parameter int unsigned ADDR_W    = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mth_valid,
    output logic              mth_ready,
    input  logic [IDX_W-1:0]  mth_index,
    input  logic [DATA_W-1:0] mth_data,
    input  logic [IDX_W-1:0]  rd_index,
    output logic [DATA_W-1:0] rd_data,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              err_mode,
    output logic              err_index
);
    logic              accept;
    logic              trig_acc;
    logic [DATA_W-1:0] tap_hi;
    logic [DATA_W-1:0] tap_lo;
    logic [DATA_W-1:0] tap_seq;

    assign accept   = mth_valid && mth_ready;
    assign trig_acc = accept && (int'(mth_index) == int'(QRY_GET_IDX));

    qsw_regfile #(
        .REG_COUNT (REG_COUNT),
        .DATA_W    (DATA_W),
        .IDX_W     (IDX_W)
    ) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (accept),
        .widx    (mth_index),
        .wdata   (mth_data),
        .ridx    (rd_index),
        .rdata   (rd_data),
        .tap_hi  (tap_hi),
        .tap_lo  (tap_lo),
        .tap_seq (tap_seq),
        .err_idx (err_index)
    );

    qsw_query_fsm #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_acc  (trig_acc),
        .trig_mode (mth_data[MODE_W-1:0]),
        .tap_hi    (tap_hi),
        .tap_lo    (tap_lo),
        .tap_seq   (tap_seq),
        .wr_ready  (wr_ready),
        .in_ready  (mth_ready),
        .wr_valid  (wr_valid),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .err_mode  (err_mode)
    );

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (mth_ready && !wr_valid && !err_mode && !err_index));
endmodule

// File: tb/qsw_engine_tb.sv
module qsw_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mth_valid = 1'b0;
    logic        mth_ready;
    logic [11:0] mth_index = '0;
    logic [31:0] mth_data = '0;
    logic [11:0] rd_index = '0;
    logic [31:0] rd_data;
    logic        wr_valid;
    logic        wr_ready = 1'b1;
    logic [63:0] wr_addr;
    logic [31:0] wr_data;
    logic        err_mode;
    logic        err_index;

    int checks = 0;
    int fails = 0;
    int done_cnt = 0;
    bit finished = 0;
    logic [95:0] exp_q[$];

    always #5 clk = ~clk;

    qsw_engine dut_i (
        .clk (clk), .rst_n (rst_n),
        .mth_valid (mth_valid), .mth_ready (mth_ready),
        .mth_index (mth_index), .mth_data (mth_data),
        .rd_index (rd_index), .rd_data (rd_data),
        .wr_valid (wr_valid), .wr_ready (wr_ready),
        .wr_addr (wr_addr), .wr_data (wr_data),
        .err_mode (err_mode), .err_index (err_index)
    );

    task automatic check(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [11:0] idx, input logic [31:0] val);
        @(negedge clk);
        while (!mth_ready) @(negedge clk);
        mth_valid = 1'b1;
        mth_index = idx;
        mth_data  = val;
        @(posedge clk);
        #1 mth_valid = 1'b0;
    endtask

    task automatic expect_write(input logic [63:0] a, input logic [31:0] d);
        exp_q.push_back({a, d});
    endtask

    task automatic read_chk(input logic [11:0] idx, input logic [31:0] exp, input string req);
        @(posedge clk);
        #1 rd_index = idx;
        @(negedge clk);
        check(rd_data == exp, req, {64'd0, rd_data}, {64'd0, exp});
    endtask

    // Scoreboard monitor: every transfer is compared with the oldest expectation
    always @(negedge clk) begin
        if (rst_n && wr_valid && wr_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 unexpected request", {wr_addr, wr_data}, 96'd0);
            end else begin
                logic [95:0] e;
                e = exp_q.pop_front();
                check({wr_addr, wr_data} == e, "R3/R9 request payload", {wr_addr, wr_data}, e);
                done_cnt++;
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(mth_ready && !wr_valid && !err_mode && !err_index, "R1 reset state",
              {92'd0, mth_ready, wr_valid, err_mode, err_index}, 96'h8);

        // R2: plain stores and the last legal word
        do_write(12'h005, 32'hA5A5_0F0F);
        read_chk(12'h005, 32'hA5A5_0F0F, "R2 store index 5");
        do_write(12'hE35, 32'h0BAD_CAFE);
        read_chk(12'hE35, 32'h0BAD_CAFE, "R2 store last index");

        // R3: write-mode trigger
        do_write(12'h6C0, 32'h1234_5678);
        do_write(12'h6C1, 32'h9ABC_DEF0);
        do_write(12'h6C2, 32'h0000_0011);
        expect_write(64'h1234_5678_9ABC_DEF0, 32'h11);
        do_write(12'h6C3, 32'h0000_0000);
        @(negedge clk);
        check(wr_valid, "R3 request raised", {95'd0, wr_valid}, 96'd1);
        read_chk(12'h6C3, 32'h0, "R8 trigger readback mode0");

        // R9: fence and unit bits set alongside mode 0
        do_write(12'h6C2, 32'h0000_0022);
        expect_write(64'h1234_5678_9ABC_DEF0, 32'h22);
        do_write(12'h6C3, 32'h0000_F010);
        read_chk(12'h6C3, 32'h0000_F010, "R8 trigger readback fence/unit");

        // R4/R5: stall the memory side
        do_write(12'h6C1, 32'h0000_4000);
        do_write(12'h6C2, 32'h0000_0033);
        @(posedge clk);
        #1 wr_ready = 1'b0;
        expect_write(64'h1234_5678_0000_4000, 32'h33);
        do_write(12'h6C3, 32'h0000_0000);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(wr_valid && wr_addr == 64'h1234_5678_0000_4000 && wr_data == 32'h33,
                  "R4 request held", {wr_addr, wr_data}, {64'h1234_5678_0000_4000, 32'h33});
            check(!mth_ready, "R5 input held off", {95'd0, mth_ready}, 96'd0);
        end
        fork
            do_write(12'h007, 32'h7777_7777);
            begin
                @(posedge clk);
                #1 wr_ready = 1'b1;
            end
        join
        read_chk(12'h007, 32'h7777_7777, "R5 held method stored later");
        @(negedge clk);
        check(!wr_valid, "R4 single transfer", {95'd0, wr_valid}, 96'd0);

        // R6: unsupported modes 1 and 3
        do_write(12'h6C3, 32'h0000_0001);
        @(negedge clk);
        check(err_mode && !wr_valid, "R6 mode 1 flag, no request",
              {94'd0, err_mode, wr_valid}, 96'd2);
        @(negedge clk);
        check(!err_mode && !wr_valid, "R6 flag one cycle", {94'd0, err_mode, wr_valid}, 96'd0);
        read_chk(12'h6C3, 32'h1, "R8 trigger readback mode1");
        do_write(12'h6C3, 32'h0000_0013);
        @(negedge clk);
        check(err_mode && !wr_valid, "R6 mode 3 flag", {94'd0, err_mode, wr_valid}, 96'd2);

        // R7: illegal indices
        do_write(12'hE36, 32'hDEAD_BEEF);
        @(negedge clk);
        check(err_index, "R7 first illegal flagged", {95'd0, err_index}, 96'd1);
        @(negedge clk);
        check(!err_index, "R7 flag one cycle", {95'd0, err_index}, 96'd0);
        do_write(12'hFFF, 32'hDEAD_BEEF);
        @(negedge clk);
        check(err_index, "R7 far illegal flagged", {95'd0, err_index}, 96'd1);
        read_chk(12'hE35, 32'h0BAD_CAFE, "R7 last word unchanged");
        read_chk(12'h005, 32'hA5A5_0F0F, "R7 word 5 unchanged");
        check(!err_mode, "R7 legal flag quiet", {95'd0, err_mode}, 96'd0);
        expect_write(64'h1234_5678_0000_4000, 32'h33);
        do_write(12'h6C3, 32'h0000_0000);
        repeat (3) @(negedge clk);

        check(exp_q.size() == 0 && done_cnt == 4, "R3 all requests seen",
              {64'd0, 32'(done_cnt)}, 96'd4);
        finish_run();
    end
endmodule